// File: doc/BRIEF.md
# Refresh-aware DRAM step sequencer

This block paces the memory-access stage that sits behind the address-map stage of a cache memory pipeline. When the map stage hands over a request, the sequencer latches the request's attributes and its serial number, then walks a four-bit step counter through a ROM. The ROM drives the DRAM control strobes and marks when the stage becomes free again. A refresh flag that arrives with the request selects the refresh half of the ROM, so refresh cycles and normal accesses share one counter but follow different strobe patterns.

The stage parks on its last step, 7, because the ROM word for that step sets the free flag. From then on the counter and the strobes hold until the next start. While a request is in flight the block also raises wait conditions toward the map stage (data-path and I/O waits) and toward the store stage (store wait). The DRAM arrays and the data path are outside this block.

Top module: `mem_stage_seq`

## Requirements
- R1: While reset is asserted, and after it, the step is 0, free is 1, RAS, CAS, chip select and shift-load are 0, the write strobe (active low) is 1, and the three wait outputs are 0.
- R2: A start takes priority over everything else. In the cycle after it the step is 0 and the strobes show the ROM word for step 0 of the selected half. This also holds when the start arrives in the middle of a busy sequence.
- R3: When the stage is not free and no start is present, the step advances by exactly one at each clock.
- R4: The ROM is addressed with {refresh flag, step}, and the refresh flag sits in address bit 4. In the default normal half: RAS is 1 in steps 0-4, chip select is 1 in steps 0-1, CAS is 1 in steps 1-3, and shift-load is 1 in step 3.
- R5: In the default refresh half, RAS is 1 in steps 0-2. CAS, chip select and shift-load stay 0, and the write strobe stays 1.
- R6: The free flag changes only on non-idle cycles and is taken from the ROM word. By default it becomes 1 on entry to step 7. A free stage with no start holds its step and its strobes.
- R7: The write strobe output is 0 only for a write request, and only in steps whose ROM write bit is low (default: steps 1-2 of the normal half). The store wait is 1 only for a write request, and only in steps whose ROM store-wait bit is low (default: step 1).
- R8: In step 6 the data wait is 1 when the request uses data and the hold-disable input is 0.
- R9: In step 7 the data wait is 1 when the request needs the data path and the stage was not free in the previous cycle. Once the stage has stayed parked for a cycle, this term no longer raises the wait.
- R10: The I/O wait is 1 in step 6 when the request is a dirty I/O fetch.
- R11: The serial number and the request attributes are captured only on a start. A change on those inputs at any other time has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start from the map stage |
| rfsh_i | input | 1 | Request is a refresh (captured on start) |
| wr_i | input | 1 | Request writes memory |
| io_fetch_i | input | 1 | Request is an I/O fetch |
| dirty_io_i | input | 1 | Request is a dirty I/O fetch |
| uses_data_i | input | 1 | Request uses the data path in step 6 |
| dpath_i | input | 1 | Request needs the data path at the end of the sequence |
| srn_i | input | SRN_W | Serial number from the map stage |
| hold_dis_i | input | 1 | Disables the step-6 data wait |
| step_o | output | 4 | Current step |
| free_o | output | 1 | Stage free |
| ras_o | output | 1 | RAS strobe |
| cas_o | output | 1 | CAS strobe |
| cs_o | output | 1 | Chip select |
| we_n_o | output | 1 | Write strobe, active low |
| shl_o | output | 1 | Shift-load enable |
| st_wait_o | output | 1 | Wait toward the store stage |
| map_wait_d_o | output | 1 | Data wait toward the map stage |
| map_wait_io_o | output | 1 | I/O wait toward the map stage |
| io_fetch_o | output | 1 | Captured I/O-fetch attribute |
| srn_o | output | SRN_W | Captured serial number |

## Verification
Some rules are checked by the embedded properties on every clock. Start forces step 0. A busy stage advances by one per clock. A free stage with no start holds its step. The serial number stays stable between starts. These rules hold whatever the ROM image contains. The properties cannot check the strobe pattern of each step, the difference between the two ROM halves, the gating of the write strobe and the store wait by the write attribute, or the one-cycle data wait on entry to step 7. The bench shows these by walking a write, a refresh and a hold-disabled read through their full sequences, with a restart in mid-sequence and a reset in mid-sequence.

// File: rtl/msq_pkg.sv
package msq_pkg;

    localparam int STEP_W    = 4;
    localparam int ADDR_W    = STEP_W + 1;
    localparam int ROM_WORDS = 1 << ADDR_W;
    localparam int HALF      = ROM_WORDS / 2;
    localparam int LAST_STEP = 7;

    typedef struct packed {
        logic we_n;   // memory write enable, active low
        logic stw_n;  // store-stage wait, active low
        logic cas;
        logic shl;    // shift-load even
        logic cs;
        logic free;
        logic st6_n;  // marks the step-6 slot when low
        logic ras;
    } ctl_word_t;

    localparam int WORD_W = $bits(ctl_word_t);

    localparam ctl_word_t IDLE_WORD = '{we_n: 1'b1, stw_n: 1'b1, cas: 1'b0, shl: 1'b0,
                                        cs: 1'b0, free: 1'b1, st6_n: 1'b1, ras: 1'b0};

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              rfsh;
        logic              was_free;
        ctl_word_t         word;
    } seq_st_t;

    // Default ROM image: normal half at 0..15, refresh half at 16..31.
    function automatic logic [ROM_WORDS*WORD_W-1:0] default_image();
        logic [ROM_WORDS*WORD_W-1:0] img;
        ctl_word_t w;
        img = '0;
        for (int a = 0; a < ROM_WORDS; a++) begin
            int  s;
            logic rf;
            s  = a % HALF;
            rf = (a >= HALF);
            w  = IDLE_WORD;
            if (s <= LAST_STEP) begin
                w.free  = (s == LAST_STEP);
                w.st6_n = (s != 6);
                if (!rf) begin
                    w.ras   = (s <= 4);
                    w.cs    = (s <= 1);
                    w.cas   = (s >= 1) && (s <= 3);
                    w.shl   = (s == 3);
                    w.we_n  = !((s == 1) || (s == 2));
                    w.stw_n = (s != 1);
                end else begin
                    w.ras   = (s <= 2);
                end
            end
            img[a*WORD_W +: WORD_W] = w;
        end
        return img;
    endfunction

endpackage

// File: rtl/msq_rom.sv
module msq_rom
    import msq_pkg::*;
#(
    parameter logic [ROM_WORDS*WORD_W-1:0] IMAGE = default_image()
) (
    input  logic [ADDR_W-1:0] addr_i,
    output ctl_word_t         word_o
);

    logic [WORD_W-1:0] tbl [ROM_WORDS];

    for (genvar g = 0; g < ROM_WORDS; g++) begin : g_word
        assign tbl[g] = IMAGE[g*WORD_W +: WORD_W];
    end

    assign word_o = ctl_word_t'(tbl[addr_i]);

endmodule

// File: rtl/msq_ctx.sv
module msq_ctx #(
    parameter int SRN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             wr_i,
    input  logic             io_fetch_i,
    input  logic             dirty_io_i,
    input  logic             uses_data_i,
    input  logic             dpath_i,
    input  logic [SRN_W-1:0] srn_i,
    output logic             wr_o,
    output logic             io_fetch_o,
    output logic             dirty_io_o,
    output logic             uses_data_o,
    output logic             dpath_o,
    output logic [SRN_W-1:0] srn_o
);

    localparam int CTX_W = SRN_W + 5;

    logic [CTX_W-1:0] ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        if (start_i) ctx_d = {srn_i, wr_i, io_fetch_i, dirty_io_i, uses_data_i, dpath_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign {srn_o, wr_o, io_fetch_o, dirty_io_o, uses_data_o, dpath_o} = ctx_q;

    // R11
    srn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(srn_o));

endmodule

// File: rtl/msq_waits.sv
module msq_waits
    import msq_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  logic              st6_n_i,
    input  logic              was_free_i,
    input  logic              uses_data_i,
    input  logic              dpath_i,
    input  logic              dirty_io_i,
    input  logic              hold_dis_i,
    output logic              map_wait_d_o,
    output logic              map_wait_io_o
);

    logic at_last;
    logic in_six;

    assign at_last = (step_i == STEP_W'(LAST_STEP));
    assign in_six  = !st6_n_i;

    // Step 7 term covers the entry cycle, before the parked state settles.
    assign map_wait_d_o  = (dpath_i && at_last && !was_free_i) ||
                           (uses_data_i && in_six && !hold_dis_i);
    assign map_wait_io_o = in_six && dirty_io_i;

endmodule

// File: rtl/mem_stage_seq.sv
module mem_stage_seq
    import msq_pkg::*;
#(
    parameter int SRN_W = 4,
    parameter logic [ROM_WORDS*WORD_W-1:0] ROM_IMAGE = default_image()
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rfsh_i,
    input  logic             wr_i,
    input  logic             io_fetch_i,
    input  logic             dirty_io_i,
    input  logic             uses_data_i,
    input  logic             dpath_i,
    input  logic [SRN_W-1:0] srn_i,
    input  logic             hold_dis_i,
    output logic [STEP_W-1:0] step_o,
    output logic             free_o,
    output logic             ras_o,
    output logic             cas_o,
    output logic             cs_o,
    output logic             we_n_o,
    output logic             shl_o,
    output logic             st_wait_o,
    output logic             map_wait_d_o,
    output logic             map_wait_io_o,
    output logic             io_fetch_o,
    output logic [SRN_W-1:0] srn_o
);

    seq_st_t           st_d, st_q;
    logic              busy;
    logic [STEP_W-1:0] step_n;
    logic              rfsh_n;
    ctl_word_t         rom_word;
    logic              wr_q, dirty_q, uses_q, dpath_q;

    // Next address: the ROM is read for the step being entered.
    always_comb begin
        busy   = !(st_q.word.free && !start_i);
        step_n = st_q.step;
        rfsh_n = st_q.rfsh;
        if (start_i) begin
            step_n = '0;
            rfsh_n = rfsh_i;
        end else if (busy) begin
            step_n = st_q.step + 1'b1;
        end
    end

    msq_rom #(.IMAGE(ROM_IMAGE)) rom_i (
        .addr_i (ADDR_W'({rfsh_n, step_n})),
        .word_o (rom_word)
    );

    always_comb begin
        st_d          = st_q;
        st_d.step     = step_n;
        st_d.rfsh     = rfsh_n;
        st_d.was_free = st_q.word.free;
        if (busy) st_d.word = rom_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.step     <= '0;
            st_q.rfsh     <= 1'b0;
            st_q.was_free <= 1'b1;
            st_q.word     <= IDLE_WORD;
        end else begin
            st_q <= st_d;
        end
    end

    msq_ctx #(.SRN_W(SRN_W)) ctx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .wr_i        (wr_i),
        .io_fetch_i  (io_fetch_i),
        .dirty_io_i  (dirty_io_i),
        .uses_data_i (uses_data_i),
        .dpath_i     (dpath_i),
        .srn_i       (srn_i),
        .wr_o        (wr_q),
        .io_fetch_o  (io_fetch_o),
        .dirty_io_o  (dirty_q),
        .uses_data_o (uses_q),
        .dpath_o     (dpath_q),
        .srn_o       (srn_o)
    );

    msq_waits waits_i (
        .step_i        (st_q.step),
        .st6_n_i       (st_q.word.st6_n),
        .was_free_i    (st_q.was_free),
        .uses_data_i   (uses_q),
        .dpath_i       (dpath_q),
        .dirty_io_i    (dirty_q),
        .hold_dis_i    (hold_dis_i),
        .map_wait_d_o  (map_wait_d_o),
        .map_wait_io_o (map_wait_io_o)
    );

    assign step_o    = st_q.step;
    assign free_o    = st_q.word.free;
    assign ras_o     = st_q.word.ras;
    assign cas_o     = st_q.word.cas;
    assign cs_o      = st_q.word.cs;
    assign shl_o     = st_q.word.shl;
    assign we_n_o    = st_q.word.we_n || !wr_q;
    assign st_wait_o = wr_q && !st_q.word.stw_n;

    // R2
    start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (step_o == '0));

    // R3
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!free_o && !start_i) |=> (step_o == $past(step_o) + 1'b1));

    // R6
    park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_o && !start_i) |=> ($stable(step_o) && $stable(ras_o) && $stable(cas_o)));

endmodule

// File: tb/mem_stage_seq_tb_top.sv
module mem_stage_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, rfsh_i = 1'b0, wr_i = 1'b0, io_fetch_i = 1'b0;
    logic       dirty_io_i = 1'b0, uses_data_i = 1'b0, dpath_i = 1'b0, hold_dis_i = 1'b0;
    logic [3:0] srn_i = 4'h0;
    logic [3:0] step_o, srn_o;
    logic       free_o, ras_o, cas_o, cs_o, we_n_o, shl_o, st_wait_o;
    logic       map_wait_d_o, map_wait_io_o, io_fetch_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] exp_srn = 4'h0;

    always #10 clk = !clk;

    mem_stage_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rfsh_i(rfsh_i), .wr_i(wr_i),
        .io_fetch_i(io_fetch_i), .dirty_io_i(dirty_io_i), .uses_data_i(uses_data_i),
        .dpath_i(dpath_i), .srn_i(srn_i), .hold_dis_i(hold_dis_i),
        .step_o(step_o), .free_o(free_o), .ras_o(ras_o), .cas_o(cas_o), .cs_o(cs_o),
        .we_n_o(we_n_o), .shl_o(shl_o), .st_wait_o(st_wait_o),
        .map_wait_d_o(map_wait_d_o), .map_wait_io_o(map_wait_io_o),
        .io_fetch_o(io_fetch_o), .srn_o(srn_o)
    );

    // {start rfsh wr dirty uses dpath hold_dis, step,
    //  free ras cas cs we_n shl st_wait wait_d wait_io}
    localparam int NV = 25;
    localparam logic [19:0] VEC [NV] = '{
        {7'b1011110, 4'd0, 9'b010110000},  // write, normal half
        {7'b0011110, 4'd1, 9'b011100100},
        {7'b0011110, 4'd2, 9'b011000000},
        {7'b0011110, 4'd3, 9'b011011000},
        {7'b0011110, 4'd4, 9'b010010000},
        {7'b0011110, 4'd5, 9'b000010000},
        {7'b0011110, 4'd6, 9'b000010011},
        {7'b0011110, 4'd7, 9'b100010010},
        {7'b0011110, 4'd7, 9'b100010000},
        {7'b1100000, 4'd0, 9'b010010000},  // refresh half
        {7'b0000000, 4'd1, 9'b010010000},
        {7'b0000000, 4'd2, 9'b010010000},
        {7'b0000000, 4'd3, 9'b000010000},
        {7'b0000000, 4'd4, 9'b000010000},
        {7'b0000000, 4'd5, 9'b000010000},
        {7'b0000000, 4'd6, 9'b000010000},
        {7'b0000000, 4'd7, 9'b100010000},
        {7'b1000101, 4'd0, 9'b010110000},  // read, hold disabled
        {7'b0000101, 4'd1, 9'b011110000},
        {7'b0000101, 4'd2, 9'b011010000},
        {7'b0000101, 4'd3, 9'b011011000},
        {7'b0000101, 4'd4, 9'b010010000},
        {7'b0000101, 4'd5, 9'b000010000},
        {7'b0000101, 4'd6, 9'b000010000},
        {7'b0000101, 4'd7, 9'b100010000}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "step", step_o, 0);
        chk(req, "free", free_o, 1);
        chk(req, "ras", ras_o, 0);
        chk(req, "cas", cas_o, 0);
        chk(req, "cs", cs_o, 0);
        chk(req, "shl", shl_o, 0);
        chk(req, "we_n", we_n_o, 1);
        chk(req, "waits", {st_wait_o, map_wait_d_o, map_wait_io_o}, 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL R3 watchdog: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk_idle("R1");                      // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");                      // R1 after release, no start

        for (int i = 0; i < NV; i++) begin
            {start_i, rfsh_i, wr_i, dirty_io_i, uses_data_i, dpath_i, hold_dis_i} = VEC[i][19:13];
            srn_i = i[3:0];
            if (VEC[i][19]) exp_srn = i[3:0];
            @(negedge clk);
            chk(VEC[i][19] ? "R2" : "R3", "step", step_o, VEC[i][12:9]);
            chk("R6", "free", free_o, VEC[i][8]);
            chk("R4 R5", "ras", ras_o, VEC[i][7]);
            chk("R4 R5", "cas", cas_o, VEC[i][6]);
            chk("R4 R5", "cs", cs_o, VEC[i][5]);
            chk("R7", "we_n", we_n_o, VEC[i][4]);
            chk("R4", "shl", shl_o, VEC[i][3]);
            chk("R7", "st_wait", st_wait_o, VEC[i][2]);
            chk("R8 R9", "wait_d", map_wait_d_o, VEC[i][1]);
            chk("R10", "wait_io", map_wait_io_o, VEC[i][0]);
            chk("R11", "srn", srn_o, exp_srn);
        end

        // R2: restart in the middle of a busy sequence
        {start_i, rfsh_i, wr_i, io_fetch_i, dirty_io_i, uses_data_i, dpath_i, hold_dis_i} = 8'b10110000;
        srn_i = 4'hA;
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3", "step before restart", step_o, 2);
        start_i = 1'b1; io_fetch_i = 1'b0; srn_i = 4'h5;
        @(negedge clk);
        chk("R2", "restart step", step_o, 0);
        chk("R2", "restart free", free_o, 0);
        chk("R2", "restart srn", srn_o, 5);
        // R11: attribute inputs change without a start
        start_i = 1'b0; io_fetch_i = 1'b1; srn_i = 4'hC; wr_i = 1'b0;
        @(negedge clk);
        chk("R11", "srn held", srn_o, 5);
        chk("R11", "io_fetch held", io_fetch_o, 0);
        chk("R7", "we_n captured write", we_n_o, 0);
        chk("R3", "step after restart", step_o, 1);

        // R1: reset in mid-sequence
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R1");
        chk("R1", "srn cleared", srn_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule